// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous host and an 8192-word by 8-bit asynchronous static RAM. It turns one host write request into a complete write cycle on the RAM pins. The request carries a 13-bit address and an 8-bit data byte over a valid/ready handshake. The block then steps the RAM through four phases, each a whole number of clock cycles set by parameters: address setup, the write overlap, post-write hold and recovery, and a return to idle. The RAM writes only during the overlap, which is the time when the active-low write strobe, the active-low select and the active-high select are all asserted together.

A parameter picks one of two cycle styles. In the strobe-led style, the two selects are asserted first and the write strobe is pulsed inside them. In the select-led style, the write strobe is lowered first and the two selects are pulsed inside it, so the RAM outputs stay high-impedance throughout. A second parameter lets the strobe-led style keep output enable low during setup and overlap. In that case the overlap is lengthened and the data drive is delayed by the RAM's output turn-off time, so the two bus drivers never fight. The RAM data bus itself is not modelled: the block provides the outgoing byte and a drive-enable line for an external tri-state buffer.

Top module: `sram_write_seq`

## Requirements
- R1: After reset and whenever no cycle is in progress, `req_ready` is 1, `ram_cs1_n`=1, `ram_cs2`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ram_dout_en`=0. After reset, `ram_addr` and `ram_dout` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle on, for SETUP_CYC + overlap length + RECOV_CYC cycles, and then returns to 1 for at least one cycle before the next request can be taken.
- R3: For the SETUP_CYC cycles right after a request is taken, `ram_addr` shows the new address and there is no write overlap.
- R4: In the strobe-led style (WE_LED=1), both selects are active (`ram_cs1_n`=0, `ram_cs2`=1) during setup, overlap and recovery. `ram_we_n` is 0 only during the overlap.
- R5: In the select-led style (WE_LED=0), `ram_we_n` is 0 during setup, overlap and recovery. The selects are active only during the overlap.
- R6: The overlap lasts max(PULSE_CYC, DSETUP_CYC) cycles. When WE_LED=1 and OE_LOW=1, it lasts max(PULSE_CYC, DSETUP_CYC, TURNOFF_CYC + DSETUP_CYC) cycles.
- R7: `ram_dout_en` is 0 during setup. When WE_LED=1 and OE_LOW=1, it rises TURNOFF_CYC cycles after the overlap begins; otherwise it rises as the overlap begins. It stays 1 for HOLD_CYC cycles after the overlap ends. The bus is never driven while the RAM could be driving it (`ram_oe_n`=0, selects active, `ram_we_n`=1).
- R8: Recovery lasts RECOV_CYC cycles after the overlap ends, and the block then returns to idle. `ram_addr` and `ram_dout` hold the accepted values from setup until the next request is taken.
- R9: `ram_oe_n` is 0 only during setup and overlap, and only when WE_LED=1 and OE_LOW=1. Otherwise it is 1.
- R10: `ram_addr` never changes in a cycle where a write overlap is present, either before or after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 13 | Write address |
| req_data | input | 8 | Write data byte |
| ram_addr | output | 13 | RAM address pins |
| ram_cs1_n | output | 1 | RAM select, active low |
| ram_cs2 | output | 1 | RAM select, active high |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dout | output | 8 | Byte to place on the RAM data bus |
| ram_dout_en | output | 1 | Drive enable for the RAM data bus buffer |

## Verification
Two events can fall in the same cycle: the last recovery cycle of one write, and a new request that the host has held valid since that write was accepted. The bench provokes this by holding `req_valid` high for long runs, so every write is followed at once by another. It expects the new request to be taken only in the single idle cycle after recovery, with the address and data unchanged until that edge. Two instances, one per cycle style, are compared pin by pin on every cycle against a phase-position model.

// File: rtl/sws_pkg.sv
// Shared types and helpers for the SRAM write sequencer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package sws_pkg;

    // Phase of one write cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_OVLP  = 2'd2,
        PH_POST  = 2'd3
    } phase_t;

    // Control pin bundle driven toward the RAM.
    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
        logic drv;
    } ctl_t;

    // Larger of two non-negative integers, usable in localparams.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sws_cnt.sv
// Phase cycle counter: counts up each clock and returns to zero on clear.
// Assumes the owner clears it at every phase boundary, so it never wraps.
module sws_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);

    // Count cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= q + W'(1);
    end

endmodule

// File: rtl/sws_seq.sv
// Phase sequencer: IDLE -> SETUP -> OVLP -> POST -> IDLE.
// Each phase lasts a fixed number of cycles, and every count must be >= 1.
// It leaves IDLE only on start, which the top raises on handshake acceptance.
module sws_seq
    import sws_pkg::*;
#(
    parameter int SETUP_N = 2,
    parameter int OVLP_N  = 4,
    parameter int POST_N  = 3,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_t        phase,
    output logic [CW-1:0] cnt
);

    logic   last;
    logic   clr;
    phase_t nxt;

    // Flag the final cycle of the current timed phase.
    always_comb begin
        unique case (phase)
            PH_SETUP: last = (cnt == CW'(SETUP_N - 1));
            PH_OVLP:  last = (cnt == CW'(OVLP_N - 1));
            PH_POST:  last = (cnt == CW'(POST_N - 1));
            default:  last = 1'b0;
        endcase
    end

    // Choose the next phase.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:  if (start) nxt = PH_SETUP;
            PH_SETUP: if (last)  nxt = PH_OVLP;
            PH_OVLP:  if (last)  nxt = PH_POST;
            PH_POST:  if (last)  nxt = PH_IDLE;
            default:             nxt = PH_IDLE;
        endcase
    end

    // Hold the counter at zero in idle and at each phase boundary.
    assign clr = (phase == PH_IDLE) || last;

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    sws_cnt #(.W(CW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .q     (cnt)
    );

endmodule

// File: rtl/sws_pins.sv
// Pin decoder: maps phase and in-phase count to RAM control levels.
// WE_LED picks strobe-led (1) or select-led (0) ordering; OE_LOW only matters
// when WE_LED=1. Assumes HOLD_N <= POST phase length.
module sws_pins
    import sws_pkg::*;
#(
    parameter int WE_LED  = 1,
    parameter int OE_LOW  = 1,
    parameter int DRV_DLY = 2,
    parameter int HOLD_N  = 1,
    parameter int CW      = 3
) (
    input  phase_t        phase,
    input  logic [CW-1:0] cnt,
    output ctl_t          ctl
);

    localparam logic OE_ACT = (WE_LED != 0) && (OE_LOW != 0);

    logic drv_ovlp;
    logic drv_post;

    // Delay the drive inside the overlap only when the RAM may still be driving.
    generate
        if (DRV_DLY == 0) begin : g_drv_now
            assign drv_ovlp = 1'b1;
        end else begin : g_drv_late
            assign drv_ovlp = (cnt >= CW'(DRV_DLY));
        end
    endgenerate

    assign drv_post = (cnt < CW'(HOLD_N));

    // Decode the control levels for the selected cycle style.
    generate
        if (WE_LED != 0) begin : g_we_led
            always_comb begin
                unique case (phase)
                    PH_SETUP: ctl = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: !OE_ACT, drv: 1'b0};
                    PH_OVLP:  ctl = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: !OE_ACT, drv: drv_ovlp};
                    PH_POST:  ctl = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: drv_post};
                    default:  ctl = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
                endcase
            end
        end else begin : g_cs_led
            always_comb begin
                unique case (phase)
                    PH_SETUP: ctl = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b0};
                    PH_OVLP:  ctl = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drv: drv_ovlp};
                    PH_POST:  ctl = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: drv_post};
                    default:  ctl = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sram_write_seq.sv
// Top of the asynchronous SRAM write sequencer.
// It takes one write per handshake, latches the address and data, and runs
// setup, overlap and recovery on the RAM pins. All intervals are in clock
// cycles. Assumes SETUP_CYC, PULSE_CYC, RECOV_CYC >= 1 and HOLD_CYC <= RECOV_CYC.
module sram_write_seq
    import sws_pkg::*;
#(
    parameter int AW          = 13,
    parameter int DW          = 8,
    parameter int WE_LED      = 1,
    parameter int OE_LOW      = 1,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 3,
    parameter int DSETUP_CYC  = 2,
    parameter int TURNOFF_CYC = 2,
    parameter int HOLD_CYC    = 1,
    parameter int RECOV_CYC   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic [AW-1:0] ram_addr,
    output logic          ram_cs1_n,
    output logic          ram_cs2,
    output logic          ram_we_n,
    output logic          ram_oe_n,
    output logic [DW-1:0] ram_dout,
    output logic          ram_dout_en
);

    localparam bit STRETCH = (WE_LED != 0) && (OE_LOW != 0);
    localparam int OVLP_BASE = max2(PULSE_CYC, DSETUP_CYC);
    localparam int OVLP_N = STRETCH ? max2(OVLP_BASE, TURNOFF_CYC + DSETUP_CYC) : OVLP_BASE;
    localparam int DRV_DLY = STRETCH ? TURNOFF_CYC : 0;
    localparam int CMAX = max2(max2(SETUP_CYC, OVLP_N), RECOV_CYC);
    localparam int CW = $clog2(CMAX + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    ctl_t          ctl;
    logic          take;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign req_ready = (phase == PH_IDLE);
    assign take      = req_valid && req_ready;

    // Latch the request so address and data stay still for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    sws_seq #(
        .SETUP_N (SETUP_CYC),
        .OVLP_N  (OVLP_N),
        .POST_N  (RECOV_CYC),
        .CW      (CW)
    ) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (take),
        .phase (phase),
        .cnt   (cnt)
    );

    sws_pins #(
        .WE_LED  (WE_LED),
        .OE_LOW  (OE_LOW),
        .DRV_DLY (DRV_DLY),
        .HOLD_N  (HOLD_CYC),
        .CW      (CW)
    ) i_pins (
        .phase (phase),
        .cnt   (cnt),
        .ctl   (ctl)
    );

    assign ram_addr    = addr_q;
    assign ram_dout    = data_q;
    assign ram_cs1_n   = ctl.cs1_n;
    assign ram_cs2     = ctl.cs2;
    assign ram_we_n    = ctl.we_n;
    assign ram_oe_n    = ctl.oe_n;
    assign ram_dout_en = ctl.drv;

endmodule

// File: rtl/sws_chk.sv
// Property checker for sram_write_seq, bound to every instance.
// Looks only at the top's ports.
module sws_chk #(
    parameter int AW     = 13,
    parameter int DW     = 8,
    parameter int WE_LED = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] ram_addr,
    input logic          ram_cs1_n,
    input logic          ram_cs2,
    input logic          ram_we_n,
    input logic          ram_oe_n,
    input logic [DW-1:0] ram_dout,
    input logic          ram_dout_en
);

    logic ovlp;
    assign ovlp = !ram_cs1_n && ram_cs2 && !ram_we_n;

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs1_n && !ram_cs2 && ram_we_n && ram_oe_n && !ram_dout_en));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_we_led_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (WE_LED != 0 && ovlp && !$past(ovlp)) |-> (!$past(ram_cs1_n) && $past(ram_cs2) && $past(ram_we_n)));

    p_cs_led_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (WE_LED == 0 && ovlp && !$past(ovlp)) |-> (!$past(ram_we_n) && $past(ram_cs1_n)));

    p_no_bus_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_oe_n && !ram_cs1_n && ram_cs2 && ram_we_n) |-> !ram_dout_en);

    p_data_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_dout_en && $past(ram_dout_en)) |-> $stable(ram_dout));

    p_addr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> (!ovlp && !$past(ovlp)));

endmodule

bind sram_write_seq sws_chk #(.AW(AW), .DW(DW), .WE_LED(WE_LED)) i_sws_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .ram_addr    (ram_addr),
    .ram_cs1_n   (ram_cs1_n),
    .ram_cs2     (ram_cs2),
    .ram_we_n    (ram_we_n),
    .ram_oe_n    (ram_oe_n),
    .ram_dout    (ram_dout),
    .ram_dout_en (ram_dout_en)
);

// File: tb/test_sram_write_seq.sv
// Bench: two instances (strobe-led with output enable low, and select-led)
// are compared on every cycle with a position-in-cycle reference model.
module test_sram_write_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Instance A: strobe-led, OE low. Overlap = max(3, 2, 2+2) = 4, drive after 2.
    logic        va, ra, cs1a, cs2a, wea, oea, dea;
    logic [12:0] aa, ma;
    logic [7:0]  da, ta;

    // Instance B: select-led. Overlap = max(3, 2) = 3, drive at start, hold 2.
    logic        vb, rb, cs1b, cs2b, web, oeb, deb;
    logic [12:0] ab, mb;
    logic [7:0]  db, tb_q;

    sram_write_seq i_sram_write_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(ra),
        .req_addr(aa), .req_data(da), .ram_addr(ma), .ram_cs1_n(cs1a),
        .ram_cs2(cs2a), .ram_we_n(wea), .ram_oe_n(oea), .ram_dout(ta),
        .ram_dout_en(dea)
    );

    sram_write_seq #(.WE_LED(0), .OE_LOW(0), .HOLD_CYC(2)) i_sram_write_seq_cs (
        .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rb),
        .req_addr(ab), .req_data(db), .ram_addr(mb), .ram_cs1_n(cs1b),
        .ram_cs2(cs2b), .ram_we_n(web), .ram_oe_n(oeb), .ram_dout(tb_q),
        .ram_dout_en(deb)
    );

    // Model state per instance: position in cycle (-1 = idle) and latched request.
    int          pa = -1, pb = -1;
    logic [12:0] la = '0, lb = '0;
    logic [7:0]  ka = '0, kb = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Expected {ready, cs1_n, cs2, we_n, oe_n, drv} for a given position.
    function automatic logic [5:0] expect_pins(input int we_led, input int oe_low,
            input int t_as, input int ov, input int d0, input int t_dh, input int pos);
        logic sel;
        if (pos < 0) return 6'b1_1_0_1_1_0;
        if (pos < t_as) begin
            sel = (we_led != 0);
            return {1'b0, !sel, sel, sel, !(we_led != 0 && oe_low != 0), 1'b0};
        end
        if (pos < t_as + ov)
            return {1'b0, 1'b0, 1'b1, 1'b0, !(we_led != 0 && oe_low != 0),
                    logic'((pos - t_as) >= d0)};
        sel = (we_led != 0);
        return {1'b0, !sel, sel, sel, 1'b1, logic'((pos - t_as - ov) < t_dh)};
    endfunction

    task automatic cmp_inst(input string nm, input int we_led, input int oe_low,
            input int ov, input int d0, input int t_dh, input int pos,
            input logic [12:0] la_i, input logic [7:0] ka_i,
            input logic r, input logic c1, input logic c2, input logic w,
            input logic o, input logic d, input logic [12:0] m, input logic [7:0] t);
        logic [5:0] e;
        string ph;
        e  = expect_pins(we_led, oe_low, 2, ov, d0, t_dh, pos);
        ph = (pos < 0) ? "R1" : (pos < 2) ? "R3" : (pos < 2 + ov) ? "R6" :
             (we_led != 0) ? "R4" : "R5";
        chk({nm, " ready R2"}, r, e[5]);
        chk({nm, " cs1_n ", ph}, c1, e[4]);
        chk({nm, " cs2 ", ph}, c2, e[3]);
        chk({nm, " we_n ", ph}, w, e[2]);
        chk({nm, " oe_n R9"}, o, e[1]);
        chk({nm, " dout_en R7"}, d, e[0]);
        chk({nm, " addr R8"}, m, la_i);
        chk({nm, " dout R8"}, t, ka_i);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        va = 0; vb = 0; aa = '0; ab = '0; da = '0; db = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of both instances.
        chk("A reset R1", {ra, cs1a, cs2a, wea, oea, dea}, 6'b110110);
        chk("B reset R1", {rb, cs1b, cs2b, web, oeb, deb}, 6'b110110);
        chk("A reset addr R1", ma, 0);
        chk("B reset dout R1", tb_q, 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 900; cyc++) begin
            // Stimulus: long held-valid runs (back-to-back), sparse, and bursty.
            if (cyc < 300)      va = 1'b1;
            else if (cyc < 600) va = (cyc % 7 == 3);
            else                va = (cyc % 13 < 2);
            vb = (cyc < 300) ? (cyc % 5 != 0) : (cyc < 600) ? 1'b1 : (cyc % 11 == 4);
            aa = (cyc % 9 == 0) ? 13'h1FFF : 13'(cyc * 613);
            ab = (cyc % 8 == 0) ? 13'h0000 : 13'(cyc * 977 + 5);
            da = (cyc % 6 == 0) ? 8'hFF : 8'(cyc * 29) ^ 8'hA5;
            db = (cyc % 10 == 0) ? 8'h00 : 8'(cyc * 53 + 1);
            #1;
            cmp_inst("A", 1, 1, 4, 2, 1, pa, la, ka, ra, cs1a, cs2a, wea, oea, dea, ma, ta);
            cmp_inst("B", 0, 0, 3, 0, 2, pb, lb, kb, rb, cs1b, cs2b, web, oeb, deb, mb, tb_q);
            @(posedge clk);
            // Model step: a request is taken only from idle (R2); cycle length
            // is setup + overlap + recovery, 2+4+3 for A and 2+3+3 for B (R6, R8).
            if (pa < 0) begin
                if (va) begin pa = 0; la = aa; ka = da; end
            end else pa = (pa == 8) ? -1 : pa + 1;
            if (pb < 0) begin
                if (vb) begin pb = 0; lb = ab; kb = db; end
            end else pb = (pb == 7) ? -1 : pb + 1;
            @(negedge clk);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule